// File: doc/BRIEF.md
# Disk Word DMA Channel

This channel moves 16-bit words between a disk data path and word-addressed memory. Software loads a 32-bit word pointer in two halves and then writes a single packed control word that holds an enable flag, a direction flag and a 14-bit word count. Writing that control word is the only way to start a transfer.

Once it is armed, the channel waits for the bus arbiter to offer a slot. For each offered slot it moves at most one word. In the read direction it takes one word from the disk input handshake and stores it to memory. In the write direction it reads one word from memory and presents it to the disk side. After each word it advances the pointer by one and lowers the count by one. When the count reaches zero the channel goes idle and raises a one-cycle completion pulse, which is meant to set an interrupt request latch.

Top module: `dskw_dma`

## Requirements
- R1: A register write with `reg_sel`=0 loads `reg_wdata` into pointer bits 31:16 and leaves bits 15:0 unchanged.
- R2: A register write with `reg_sel`=1 loads `reg_wdata` into pointer bits 15:0 and leaves bits 31:16 unchanged.
- R3: A register write with `reg_sel`=2 loads the control word. Bit 15 is enable, bit 14 is direction (1 = memory to disk) and bits 13:0 are the word count. `busy` is high from the next cycle when enable is set and the count is non-zero.
- R4: A word moves (`slot_taken` high) only in a cycle where `busy`, `slot_offer` and `reg_wr` low all hold. In the read direction `rd_valid` must also be high. No more than one word moves per cycle.
- R5: A read transfer drives `mem_we` high, with `mem_wdata` equal to `rd_word` and `rd_ready` high in the same cycle.
- R6: A write transfer drives `disk_wvalid` high with `disk_wdata` equal to `mem_rdata` in the same cycle, and `mem_we` stays low.
- R7: `mem_addr` is the pointer modulo 2^MEM_AW. Each transfer advances the pointer by one, so the next `mem_addr` is one higher, wrapping at the memory size.
- R8: After the transfer that brings the count to zero, no further transfers occur, and `done` is high for exactly the one following cycle.
- R9: A control write with enable clear or with a zero count leaves the channel idle. No transfer occurs and `done` is never raised.
- R10: After reset the pointer is zero, `busy`, `done` and `slot_taken` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pointer high, 1 pointer low, 2 control |
| reg_wdata | input | 16 | Register write data |
| slot_offer | input | 1 | Bus slot offered this cycle |
| slot_taken | output | 1 | Slot used for a word transfer |
| rd_word | input | 16 | Word from the disk side |
| rd_valid | input | 1 | `rd_word` is valid |
| rd_ready | output | 1 | `rd_word` consumed this cycle |
| disk_wdata | output | 16 | Word to the disk side |
| disk_wvalid | output | 1 | `disk_wdata` valid this cycle |
| mem_addr | output | MEM_AW | Word address, pointer masked to memory size |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data at `mem_addr` (combinational) |
| busy | output | 1 | Channel armed with words left |
| done | output | 1 | One-cycle completion pulse |

## Verification
A fault in the pointer shows on `mem_addr` in the first transfer after the fault. A wrong half-merge shows on the two bits above bit 15 that the default memory size exposes. A count that is off by one moves one word too many or too few. That shows as a `slot_taken` in the cycle where the bench expects the channel to be idle, or as a `done` pulse one cycle early or late. A wrong direction flag or a lost `rd_valid` gate shows in the same cycle as a write strobe on the wrong side or as a slot taken without data.

// File: rtl/dskw_pkg.sv
package dskw_pkg;
  localparam int CNT_W  = 14;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SEL_PTR_HI = 2'd0,
    SEL_PTR_LO = 2'd1,
    SEL_CTRL   = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic             en;
    logic             to_disk;
    logic [CNT_W-1:0] count;
  } ctl_word_t;

  // Replace one half of a pointer and keep the other half.
  function automatic logic [31:0] merge_half(logic [31:0] cur, logic upper,
                                             logic [WORD_W-1:0] d);
    return upper ? {d, cur[15:0]} : {cur[31:16], d};
  endfunction

  // The channel is armed only if enable is set and there are words left.
  function automatic logic arms(ctl_word_t w);
    return w.en && (w.count != '0);
  endfunction
endpackage

// File: rtl/dskw_ptr.sv
module dskw_ptr
  import dskw_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [WORD_W-1:0] d,
  input  logic              step,
  output logic [PTR_W-1:0]  ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ptr <= '0;
    else if (ld_hi || ld_lo) ptr <= merge_half(ptr, ld_hi, d);
    else if (step)          ptr <= ptr + 1'b1;
  end

  // R1
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> ptr[15:0] == $past(ptr[15:0]));
  // R2
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> ptr[31:16] == $past(ptr[31:16]));
endmodule

// File: rtl/dskw_ctl.sv
module dskw_ctl
  import dskw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [WORD_W-1:0] d,
  input  logic              step,
  output logic              busy,
  output logic              to_disk,
  output logic              done
);
  ctl_word_t        w_in;
  logic [CNT_W-1:0] remain;
  logic             last_step;

  assign w_in      = ctl_word_t'(d);
  assign last_step = step && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      to_disk <= 1'b0;
      remain  <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_step;
      if (ld) begin
        busy    <= arms(w_in);
        to_disk <= w_in.to_disk;
        remain  <= w_in.count;
      end else if (step) begin
        remain <= remain - 1'b1;
        if (last_step) busy <= 1'b0;
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !arms(w_in)) |=> (!busy && !done));
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy || $past(ld));
endmodule

// File: rtl/dskw_dma.sv
module dskw_dma
  import dskw_pkg::*;
#(
  parameter int MEM_AW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [15:0]       reg_wdata,
  input  logic              slot_offer,
  output logic              slot_taken,
  input  logic [15:0]       rd_word,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic [15:0]       disk_wdata,
  output logic              disk_wvalid,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              busy,
  output logic              done
);
  localparam int PTR_W = 32;

  logic             ld_hi, ld_lo, ld_ctl;
  logic             xfer, to_disk, word_ready;
  logic [PTR_W-1:0] ptr;

  assign ld_hi  = reg_wr && (reg_sel == SEL_PTR_HI);
  assign ld_lo  = reg_wr && (reg_sel == SEL_PTR_LO);
  assign ld_ctl = reg_wr && (reg_sel == SEL_CTRL);

  // A read needs a word from the disk side. A write always has one.
  assign word_ready = to_disk || rd_valid;
  assign xfer       = busy && slot_offer && !reg_wr && word_ready;

  dskw_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .d(reg_wdata), .step(xfer), .ptr(ptr)
  );

  dskw_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ld(ld_ctl), .d(reg_wdata),
    .step(xfer), .busy(busy), .to_disk(to_disk), .done(done)
  );

  assign mem_addr    = ptr[MEM_AW-1:0];
  assign slot_taken  = xfer;
  assign mem_we      = xfer && !to_disk;
  assign mem_wdata   = rd_word;
  assign rd_ready    = xfer && !to_disk;
  assign disk_wvalid = xfer && to_disk;
  assign disk_wdata  = mem_rdata;

  // R4
  slot_needs_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_taken |-> (slot_offer && busy && !reg_wr));
  // R4
  read_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> rd_valid);
  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_taken |=> mem_addr == MEM_AW'($past(mem_addr) + 1'b1));
  // R6
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && disk_wvalid));
  // R8
  idle_no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !slot_taken);
endmodule

// File: tb/test_dskw_dma.sv
module test_dskw_dma;
  localparam int AW = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, slot_offer = 0, rd_valid = 0;
  logic [1:0] reg_sel = 0;
  logic [15:0] reg_wdata = 0, rd_word = 0, mem_rdata = 0;
  logic slot_taken, rd_ready, disk_wvalid, mem_we, busy, done;
  logic [15:0] disk_wdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dskw_dma #(.MEM_AW(AW)) i_dskw_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .slot_offer(slot_offer), .slot_taken(slot_taken),
    .rd_word(rd_word), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .disk_wdata(disk_wdata), .disk_wvalid(disk_wvalid), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  // Fields per vector: ptr high, ptr low, control word, rd_valid gap.
  localparam logic [51:0] VEC [7] = '{
    {16'h0000, 16'h0100, 16'h8003, 4'd0},
    {16'h0001, 16'h0200, 16'hC004, 4'd0},
    {16'h0003, 16'hFFFF, 16'h8002, 4'd0},
    {16'h0002, 16'h0010, 16'h8004, 4'd3},
    {16'h0000, 16'h0000, 16'h0005, 4'd0},
    {16'h0000, 16'h0040, 16'h8000, 4'd0},
    {16'h0000, 16'h0050, 16'hC001, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!busy && !done && !slot_taken, "R10 idle", {busy, done, slot_taken}, 0);
    chk(mem_addr == 0, "R10 ptr", mem_addr, 0);

    foreach (VEC[v]) begin
      logic [15:0] hi, lo, ctl;
      int gap, rem, nxt_rem;
      logic [AW-1:0] addr;
      bit dir, pred, done_due, saw_done;
      hi = VEC[v][51:36]; lo = VEC[v][35:20]; ctl = VEC[v][19:4]; gap = int'(VEC[v][3:0]);
      wr_reg(2'd0, hi);
      wr_reg(2'd1, lo);
      wr_reg(2'd2, ctl);
      rem  = ctl[15] ? int'(ctl[13:0]) : 0;   // R3 packing
      dir  = ctl[14];
      addr = AW'({hi, lo});
      done_due = 0; saw_done = 0;
      #1;
      chk(busy == (rem != 0), "R3 busy", busy, rem != 0);
      chk(mem_addr == addr, "R1 R2 pointer", mem_addr, addr);
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        slot_offer = 1;
        rd_valid  = (gap == 0) || (i % gap != gap - 1);
        rd_word   = 16'hA000 + 16'(i);
        mem_rdata = 16'h5000 + 16'(i);
        #1;
        chk(done == done_due, "R8 R9 done", done, done_due);
        if (done) saw_done = 1;
        pred = (rem > 0) && (dir || rd_valid);
        chk(slot_taken == pred, "R4 R8 slot", slot_taken, pred);
        if (pred) begin
          chk(mem_addr == addr, "R7 addr", mem_addr, addr);
          if (!dir) chk(mem_we && rd_ready && mem_wdata == rd_word, "R5 read",
                        {mem_we, rd_ready, mem_wdata}, {2'b11, rd_word});
          else chk(disk_wvalid && !mem_we && disk_wdata == mem_rdata, "R6 write",
                   {disk_wvalid, mem_we, disk_wdata}, {2'b10, mem_rdata});
        end
        nxt_rem  = pred ? rem - 1 : rem;
        done_due = pred && (nxt_rem == 0);
        if (pred) addr = addr + 1'b1;
        rem = nxt_rem;
      end
      slot_offer = 0;
      chk(saw_done == (ctl[15] && ctl[13:0] != 0), "R8 R9 done seen", saw_done,
          ctl[15] && ctl[13:0] != 0);
    end

    // R1/R2 high bits only visible above bit 15
    wr_reg(2'd1, 16'h1234);
    wr_reg(2'd0, 16'h0002);
    #1 chk(mem_addr == 18'h21234, "R1 keep low", mem_addr, 18'h21234);
    wr_reg(2'd1, 16'h0007);
    #1 chk(mem_addr == 18'h20007, "R2 keep high", mem_addr, 18'h20007);

    // R4: no transfer in a register-write cycle even with a slot offered
    wr_reg(2'd2, 16'hC002);
    @(negedge clk);
    slot_offer = 1; reg_wr = 1; reg_sel = 2'd3; reg_wdata = 16'hFFFF;
    #1 chk(!slot_taken, "R4 write blocks", slot_taken, 0);
    @(negedge clk);
    reg_wr = 0;
    #1 chk(slot_taken && mem_addr == 18'h20007, "R4 resumes", {slot_taken, mem_addr}, {1'b1, 18'h20007});
    @(negedge clk);
    slot_offer = 0;

    // R10: reset mid-transfer
    rst_n = 0;
    #1 chk(!busy && mem_addr == 0, "R10 reset", {busy, mem_addr}, 0);
    rst_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule